// File: doc/BRIEF.md
# ADC Conversion Strobe Generator

This block turns a single conversion reference into the set of pulses that the rest of an analog acquisition path needs. The conversion reference is either the terminal-count pulse of an internal interval counter, or an external trigger. The external trigger is picked from a pool of general-purpose trigger pins, backplane trigger lines and a dedicated stop input. Every conversion advances an external channel multiplexer. A divide-by-N count of conversions steps a channel-configuration queue. When that queue reports empty, a rewind pulse lets it be refilled for the next pass.

On the data side, the ADC's start and end of conversion status lines are synchronized. A data-queue write strobe, produced in two identical copies, fires only after a conversion that was seen to start has also been seen to finish. A DMA request is derived from the data-queue full, half-full and empty flags, under a two-bit mode. All outputs are one-cycle pulses or levels, synchronous to `clk`.

Top module: `adc_strobe_gen`

## Requirements
- R1: With `conv_sel_ext`=0 the conversion reference is `int_tc`, and a high `int_tc` makes `mux_adv` high in the next cycle. With `conv_sel_ext`=1, `int_tc` is ignored and the selected external signal is used. That signal passes through a two-flop synchronizer and rising-edge detect, so `mux_adv` goes high three clock edges after the input rises.
- R2: `ext_sel` values 0..9 pick `gp_trig[0..9]`, values 10..16 pick `bp_trig[0..6]`, value 17 picks `stop_in`, and any larger value picks a constant low. Inputs that are not selected cause no pulse.
- R3: `mux_adv` is a one-cycle pulse for every conversion reference.
- R4: `cfgq_adv` pulses together with `mux_adv` on every `div_n`-th conversion, and the count restarts after each advance. A `div_n` of 0 or 1 advances on every conversion.
- R5: `cfgq_rewind` is a one-cycle pulse in the cycle after `cfg_q_empty` rises. It fires only once per empty event, however long the flag stays high.
- R6: `dq_wr` and `dq_wr_b` pulse together for one cycle, three edges after `adc_eoc` rises, but only if a synchronized rising edge of `adc_soc` has been seen since the last end of conversion. An end of conversion with no preceding start produces no write.
- R7: `dma_req` follows the flags one cycle later according to `dreq_mode`: 00 means not empty, 01 means half-full, 10 means full, 11 means always low.
- R8: Synchronous reset `rst` forces all outputs low in the following cycle and restarts the divide-by-N count.
- R9: An external trigger that is held high gives exactly one conversion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_sel_ext | input | 1 | 0 = internal terminal count, 1 = external trigger |
| ext_sel | input | 5 | External trigger index |
| gp_trig | input | 10 | General-purpose trigger pins (asynchronous) |
| bp_trig | input | 7 | Backplane trigger lines (asynchronous) |
| stop_in | input | 1 | Dedicated stop input (asynchronous) |
| int_tc | input | 1 | Internal interval counter terminal count (synchronous) |
| adc_soc | input | 1 | ADC start-of-conversion status (asynchronous) |
| adc_eoc | input | 1 | ADC end-of-conversion status (asynchronous) |
| cfg_q_empty | input | 1 | Configuration queue empty flag (synchronous) |
| div_n | input | 8 | Conversions per configuration-queue advance |
| dreq_mode | input | 2 | DMA request mode |
| dq_full | input | 1 | Data queue full flag |
| dq_half | input | 1 | Data queue half-full flag |
| dq_empty | input | 1 | Data queue empty flag |
| mux_adv | output | 1 | External multiplexer advance pulse |
| cfgq_adv | output | 1 | Configuration queue advance pulse |
| cfgq_rewind | output | 1 | Configuration queue rewind pulse |
| dq_wr | output | 1 | Data queue write strobe |
| dq_wr_b | output | 1 | Second copy of the data queue write strobe |
| dma_req | output | 1 | DMA request |

## Verification
The hardest case to reach from the ports is a divide-by-N count stopped partway by reset. In that case the count left inside cannot be seen until later advances either land on schedule or come early. The stimulus sets N to three, issues two conversions, pulses reset, and then counts three more conversions, expecting the advance only on the third. External triggers are also held high across many cycles, and unselected pins are toggled, to show that exactly one pulse, or none, reaches the multiplexer output.

// File: rtl/adc_strobe_gen.sv
`timescale 1ns/1ps
module adc_strobe_gen #(
  parameter int N_GP  = 10,
  parameter int N_BP  = 7,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_sel_ext,
  input  logic [4:0]       ext_sel,
  input  logic [N_GP-1:0]  gp_trig,
  input  logic [N_BP-1:0]  bp_trig,
  input  logic             stop_in,
  input  logic             int_tc,
  input  logic             adc_soc,
  input  logic             adc_eoc,
  input  logic             cfg_q_empty,
  input  logic [DIV_W-1:0] div_n,
  input  logic [1:0]       dreq_mode,
  input  logic             dq_full,
  input  logic             dq_half,
  input  logic             dq_empty,
  output logic             mux_adv,
  output logic             cfgq_adv,
  output logic             cfgq_rewind,
  output logic             dq_wr,
  output logic             dq_wr_b,
  output logic             dma_req
);
  localparam int N_SRC = N_GP + N_BP + 1;
  localparam int SEL_SPAN = 32;

  logic [SEL_SPAN-1:0] src_pad;
  logic ext_sig;
  logic [2:0] sy1, sy2, sy3;
  logic [2:0] rise;
  logic conv;
  logic [DIV_W-1:0] cnt;
  logic div_hit;
  logic empty_d;
  logic busy;

  assign src_pad = {{(SEL_SPAN-N_SRC){1'b0}}, stop_in, bp_trig, gp_trig};
  assign ext_sig = src_pad[ext_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= '0;
      sy2 <= '0;
      sy3 <= '0;
    end else begin
      sy1 <= {adc_eoc, adc_soc, ext_sig};
      sy2 <= sy1;
      sy3 <= sy2;
    end
  end

  assign rise    = sy2 & ~sy3;
  assign conv    = conv_sel_ext ? rise[0] : int_tc;
  assign div_hit = ({1'b0, cnt} + 1'b1) >= {1'b0, div_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      empty_d     <= 1'b0;
      busy        <= 1'b0;
      mux_adv     <= 1'b0;
      cfgq_adv    <= 1'b0;
      cfgq_rewind <= 1'b0;
      dq_wr       <= 1'b0;
      dq_wr_b     <= 1'b0;
      dma_req     <= 1'b0;
    end else begin
      mux_adv  <= conv;
      cfgq_adv <= conv & div_hit;
      if (conv) cnt <= div_hit ? '0 : cnt + 1'b1;

      empty_d     <= cfg_q_empty;
      cfgq_rewind <= cfg_q_empty & ~empty_d;

      dq_wr   <= rise[2] & (busy | rise[1]);
      dq_wr_b <= rise[2] & (busy | rise[1]);
      if (rise[2])      busy <= 1'b0;
      else if (rise[1]) busy <= 1'b1;

      unique case (dreq_mode)
        2'b00:   dma_req <= ~dq_empty;
        2'b01:   dma_req <= dq_half;
        2'b10:   dma_req <= dq_full;
        default: dma_req <= 1'b0;
      endcase
    end
  end
endmodule

module adc_strobe_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_sel_ext,
  input logic       int_tc,
  input logic       adc_eoc,
  input logic       cfg_q_empty,
  input logic [1:0] dreq_mode,
  input logic       mux_adv,
  input logic       cfgq_adv,
  input logic       cfgq_rewind,
  input logic       dq_wr,
  input logic       dq_wr_b,
  input logic       dma_req
);
  a_r3_int_conv_pulses: assert property (@(posedge clk) disable iff (rst)
    (int_tc && !conv_sel_ext) |=> mux_adv);
  a_r4_adv_with_mux: assert property (@(posedge clk) disable iff (rst)
    cfgq_adv |-> mux_adv);
  a_r5_rewind_single: assert property (@(posedge clk) disable iff (rst)
    cfgq_rewind |=> !cfgq_rewind);
  a_r5_rewind_on_rise: assert property (@(posedge clk) disable iff (rst)
    cfgq_rewind |-> ($past(cfg_q_empty) && !$past(cfg_q_empty, 2)));
  a_r6_copies_match: assert property (@(posedge clk) disable iff (rst)
    dq_wr |-> dq_wr_b);
  a_r6_write_after_eoc: assert property (@(posedge clk) disable iff (rst)
    dq_wr |-> $past(adc_eoc, 3));
  a_r7_mode_off: assert property (@(posedge clk) disable iff (rst)
    (dreq_mode == 2'b11) |=> !dma_req);
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !(mux_adv || cfgq_adv || cfgq_rewind || dq_wr || dq_wr_b || dma_req));
endmodule

bind adc_strobe_gen adc_strobe_gen_chk u_chk (
  .clk(clk), .rst(rst), .conv_sel_ext(conv_sel_ext), .int_tc(int_tc),
  .adc_eoc(adc_eoc), .cfg_q_empty(cfg_q_empty), .dreq_mode(dreq_mode),
  .mux_adv(mux_adv), .cfgq_adv(cfgq_adv), .cfgq_rewind(cfgq_rewind),
  .dq_wr(dq_wr), .dq_wr_b(dq_wr_b), .dma_req(dma_req)
);

// File: tb/adc_strobe_gen_test.sv
`timescale 1ns/1ps
module adc_strobe_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_sel_ext = 1'b0;
  logic [4:0] ext_sel = '0;
  logic [9:0] gp_trig = '0;
  logic [6:0] bp_trig = '0;
  logic stop_in = 1'b0, int_tc = 1'b0, adc_soc = 1'b0, adc_eoc = 1'b0;
  logic cfg_q_empty = 1'b0;
  logic [7:0] div_n = 8'd1;
  logic [1:0] dreq_mode = 2'b11;
  logic dq_full = 1'b0, dq_half = 1'b0, dq_empty = 1'b1;
  logic mux_adv, cfgq_adv, cfgq_rewind, dq_wr, dq_wr_b, dma_req;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  adc_strobe_gen uut (
    .clk(clk), .rst(rst), .conv_sel_ext(conv_sel_ext), .ext_sel(ext_sel),
    .gp_trig(gp_trig), .bp_trig(bp_trig), .stop_in(stop_in), .int_tc(int_tc),
    .adc_soc(adc_soc), .adc_eoc(adc_eoc), .cfg_q_empty(cfg_q_empty),
    .div_n(div_n), .dreq_mode(dreq_mode), .dq_full(dq_full), .dq_half(dq_half),
    .dq_empty(dq_empty), .mux_adv(mux_adv), .cfgq_adv(cfgq_adv),
    .cfgq_rewind(cfgq_rewind), .dq_wr(dq_wr), .dq_wr_b(dq_wr_b), .dma_req(dma_req)
  );

  // {mode[1:0], full, half, empty, expected}
  localparam logic [5:0] DMA_VEC [0:7] = '{
    6'b00_0_0_1_0, 6'b00_0_0_0_1, 6'b01_0_1_0_1, 6'b01_0_0_0_0,
    6'b10_1_1_0_1, 6'b10_0_1_0_0, 6'b11_1_1_0_0, 6'b11_0_0_0_0
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic int_conv(output logic m, output logic a);
    int_tc = 1'b1;
    @(negedge clk);
    m = mux_adv;
    a = cfgq_adv;
    int_tc = 1'b0;
    @(negedge clk);
  endtask

  task automatic ext_expect(input string req, input logic exp);
    @(negedge clk);
    @(negedge clk);
    check(req, mux_adv, 1'b0);
    @(negedge clk);
    check(req, mux_adv, exp);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R9", mux_adv, 1'b0);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic m, a;
    repeat (3) @(negedge clk);
    check("R8", mux_adv | cfgq_adv | cfgq_rewind | dq_wr | dq_wr_b | dma_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R7 table of DMA request modes
    for (int i = 0; i < 8; i++) begin
      {dreq_mode, dq_full, dq_half, dq_empty} = DMA_VEC[i][5:1];
      @(negedge clk);
      check("R7", dma_req, DMA_VEC[i][0]);
    end
    dreq_mode = 2'b11;

    // R3/R4 divide by three
    div_n = 8'd3;
    for (int i = 0; i < 6; i++) begin
      int_conv(m, a);
      check("R3", m, 1'b1);
      check("R4", a, (i % 3) == 2);
    end
    // R4 N=1 and N=0
    div_n = 8'd1;
    for (int i = 0; i < 3; i++) begin
      int_conv(m, a);
      check("R4", a, 1'b1);
    end
    div_n = 8'd0;
    int_conv(m, a);
    check("R4", a, 1'b1);

    // R8 reset mid-count
    div_n = 8'd3;
    int_conv(m, a);
    int_conv(m, a);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      int_conv(m, a);
      check("R8", a, i == 2);
    end

    // R1 internal ignored when external selected
    conv_sel_ext = 1'b1;
    ext_sel = 5'd4;
    @(negedge clk);
    int_conv(m, a);
    check("R1", m, 1'b0);

    // R1/R9 external gp pin held high
    gp_trig[4] = 1'b1;
    ext_expect("R1", 1'b1);
    gp_trig[4] = 1'b0;
    repeat (3) @(negedge clk);
    // R2 unselected pin
    gp_trig[5] = 1'b1;
    ext_expect("R2", 1'b0);
    gp_trig[5] = 1'b0;
    repeat (3) @(negedge clk);
    // R2 backplane line 2 via index 12
    ext_sel = 5'd12;
    @(negedge clk);
    bp_trig[2] = 1'b1;
    ext_expect("R2", 1'b1);
    bp_trig[2] = 1'b0;
    repeat (3) @(negedge clk);
    // R2 stop input via index 17
    ext_sel = 5'd17;
    @(negedge clk);
    stop_in = 1'b1;
    ext_expect("R2", 1'b1);
    stop_in = 1'b0;
    repeat (3) @(negedge clk);
    // R2 out of range index
    ext_sel = 5'd20;
    @(negedge clk);
    gp_trig = '1; bp_trig = '1; stop_in = 1'b1;
    ext_expect("R2", 1'b0);
    gp_trig = '0; bp_trig = '0; stop_in = 1'b0;
    conv_sel_ext = 1'b0;
    repeat (4) @(negedge clk);

    // R5 rewind once per empty event
    cfg_q_empty = 1'b1;
    @(negedge clk);
    check("R5", cfgq_rewind, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5", cfgq_rewind, 1'b0);
    end
    cfg_q_empty = 1'b0;
    @(negedge clk);
    check("R5", cfgq_rewind, 1'b0);
    cfg_q_empty = 1'b1;
    @(negedge clk);
    check("R5", cfgq_rewind, 1'b1);
    cfg_q_empty = 1'b0;

    // R6 end of conversion without start is ignored
    adc_eoc = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6", dq_wr | dq_wr_b, 1'b0);
    end
    adc_eoc = 1'b0;
    repeat (3) @(negedge clk);
    // R6 start then end
    adc_soc = 1'b1;
    repeat (4) @(negedge clk);
    adc_soc = 1'b0;
    adc_eoc = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6", dq_wr, 1'b0);
    @(negedge clk);
    check("R6", dq_wr, 1'b1);
    check("R6", dq_wr_b, 1'b1);
    @(negedge clk);
    check("R6", dq_wr | dq_wr_b, 1'b0);
    adc_eoc = 1'b0;
    repeat (3) @(negedge clk);
    // R6 second end with no new start
    adc_eoc = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6", dq_wr, 1'b0);
    end
    adc_eoc = 1'b0;

    // R8 reset clears a live DMA request
    dreq_mode = 2'b00;
    dq_empty = 1'b0;
    @(negedge clk);
    check("R7", dma_req, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check("R8", dma_req, 1'b0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule